// File: doc/BRIEF.md
# Fifth-Order 65-Level Noise Shaper

This block turns a stream of oversampled audio samples into a stream of coarse signed codes whose quantization error has been pushed out of the audio band and up toward frequencies above roughly 100 kHz. A later stage maps these codes onto output elements and filters the result to analog. Each accepted input sample advances a fifth-order loop filter by one step. The filter is a chain of five integrators. The first integrator stands alone. The second and third integrators form one resonator pair, and the fourth and fifth form another. The current output code is subtracted, with its own gain, at the input of every integrator.

The output code is the rounded and clipped value of the last integrator. It lies in the range -32 to +32, which gives 65 levels. It is held in a single register and is the feedback value for the next step, so the loop carries exactly one register of latency. Every gain is a fixed-point parameter with FRAC fractional bits, so the value 1 << FRAC means a gain of 1.0. The arithmetic is pure integer arithmetic and can be reproduced bit for bit by a 64-bit integer model.

Top module: `nsh5_modulator`

## Requirements
- R1: On synchronous reset (rst high at a rising clock edge), all five integrators, the output code and the overload flag become 0, and out_valid becomes 0.
- R2: out_valid is high in the cycle after each cycle in which in_valid was high. It is low otherwise. The loop produces exactly one code per accepted sample.
- R3: While in_valid is low, no state advances. out_code and overload keep their values, and the code sequence that follows is the same as it would be with no gap.
- R4: In each accepted step, every integrator k is updated from the old state, the old code v and the input sample u, as follows. The drive is d1 = B*u - A1*(v<<QSHIFT). For k = 2 to 5, the drive is dk = Ck*x(k-1) - Ak*(v<<QSHIFT), minus G1*x3 for k = 2 and minus G2*x5 for k = 4. The new value is xk + (dk >>> FRAC), where >>> is an arithmetic shift that rounds toward minus infinity.
- R5: The new code is (x5_new + 2^(QSHIFT-1)) >>> QSHIFT, clipped to the range -32 to +32. It is used as the feedback value in the next step, which gives one register of latency.
- R6: Each integrator saturates at its signed STATE_W-bit limits, which are -2^(STATE_W-1) and 2^(STATE_W-1)-1.
- R7: overload goes high after any accepted step in which an integrator saturated or the code was clipped. Only reset clears it.
- R8: Starting from the reset state, a stream of zero-valued input samples produces only zero codes and leaves overload at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present; the loop advances one step |
| in_sample | input | IN_W | Signed input sample, integer units of the integrator scale |
| out_valid | output | 1 | A new code is present on out_code |
| out_code | output | CODE_W | Signed quantizer code, -32 to +32 |
| overload | output | 1 | Sticky flag: an integrator saturated or the code was clipped |

## Verification
A wrong value in the last integrator changes the rounded code on the very next accepted sample. A fault in an earlier stage has to travel down the chain, so it can take up to five accepted samples before it shows as a code difference. After that, the feedback spreads it into every later code. The bench therefore compares every code and the overload flag against an exact integer model. It uses input patterns that reach the saturation and clipping boundaries, and it inserts idle gaps between samples, so that a single wrong bit anywhere in the state shows up as a lasting mismatch and not as noise.

// File: rtl/nsh_pkg.sv
package nsh_pkg;
   // Loop order of the modulator.
   localparam int ORDER = 5;
   // Number of resonator pairs.
   localparam int NUM_RES = (ORDER - 1) / 2;

   // Stage i (counted from 0) receives resonator feedback from stage i+1.
   function automatic bit takes_resonator(int i);
      return ((i % 2) == 1) && ((i + 1) < ORDER);
   endfunction

   // Index of the resonator gain used by stage i.
   function automatic int res_slot(int i);
      return (i - 1) / 2;
   endfunction
endpackage

// File: rtl/nsh_integrator.sv
module nsh_integrator #(
   parameter int STATE_W = 24,
   parameter int ACC_W   = 46,
   parameter int FRAC    = 12
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      step,
   input  logic signed [ACC_W-1:0]   drive,
   output logic signed [STATE_W-1:0] state,
   output logic signed [STATE_W-1:0] state_nxt,
   output logic                      sat
);
   localparam logic signed [ACC_W-1:0] HI =
      {{(ACC_W-STATE_W+1){1'b0}}, {(STATE_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] LO =
      {{(ACC_W-STATE_W+1){1'b1}}, {(STATE_W-1){1'b0}}};

   logic signed [ACC_W-1:0] scaled;
   logic signed [ACC_W-1:0] sum;

   always_comb begin
      scaled = drive >>> FRAC;
      sum    = ACC_W'(state) + scaled;
      if (sum > HI) begin
         state_nxt = HI[STATE_W-1:0];
         sat       = 1'b1;
      end else if (sum < LO) begin
         state_nxt = LO[STATE_W-1:0];
         sat       = 1'b1;
      end else begin
         state_nxt = sum[STATE_W-1:0];
         sat       = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       state <= '0;
      else if (step) state <= state_nxt;
   end
endmodule

// File: rtl/nsh_quantizer.sv
module nsh_quantizer #(
   parameter int STATE_W  = 24,
   parameter int QSHIFT   = 16,
   parameter int MAX_CODE = 32,
   parameter int CODE_W   = 7
) (
   input  logic signed [STATE_W-1:0] level,
   output logic signed [CODE_W-1:0]  code,
   output logic                      clip
);
   localparam int RW = STATE_W + 1;
   localparam logic signed [RW-1:0] HALF = RW'(1) << (QSHIFT - 1);
   localparam logic signed [RW-1:0] QMAX = RW'(MAX_CODE);
   localparam logic signed [RW-1:0] QMIN = -QMAX;

   logic signed [RW-1:0] rnd;

   always_comb begin
      rnd = (RW'(level) + HALF) >>> QSHIFT;
      if (rnd > QMAX) begin
         code = QMAX[CODE_W-1:0];
         clip = 1'b1;
      end else if (rnd < QMIN) begin
         code = QMIN[CODE_W-1:0];
         clip = 1'b1;
      end else begin
         code = rnd[CODE_W-1:0];
         clip = 1'b0;
      end
   end
endmodule

// File: rtl/nsh5_modulator.sv
module nsh5_modulator
   import nsh_pkg::*;
#(
   parameter int IN_W    = 24,
   parameter int STATE_W = 24,
   parameter int COEF_W  = 18,
   parameter int FRAC    = 12,
   parameter int QSHIFT  = 16,
   parameter int LEVELS  = 65,
   parameter int B_COEF  = 205,
   parameter int A_COEF [ORDER]   = '{205, 819, 1638, 2458, 3277},
   parameter int C_COEF [ORDER-1] = '{4096, 4096, 4096, 4096},
   parameter int G_COEF [NUM_RES] = '{8, 8},
   localparam int MAX_CODE = (LEVELS - 1) / 2,
   localparam int CODE_W   = $clog2(MAX_CODE + 1) + 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [IN_W-1:0]   in_sample,
   output logic                     out_valid,
   output logic signed [CODE_W-1:0] out_code,
   output logic                     overload
);
   localparam int ACC_W = STATE_W + COEF_W + 4;

   // Elaboration-time parameter checks
   if (IN_W > STATE_W) begin : g_bad_in_w
      $error("IN_W must not exceed STATE_W");
   end
   if ((LEVELS % 2) == 0 || LEVELS < 3) begin : g_bad_levels
      $error("LEVELS must be odd and at least 3");
   end
   if (QSHIFT < 1 || QSHIFT + CODE_W > STATE_W) begin : g_bad_qshift
      $error("QSHIFT must leave room for the full code range in the state");
   end
   if (FRAC < 0 || FRAC >= ACC_W) begin : g_bad_frac
      $error("FRAC out of range");
   end

   logic signed [STATE_W-1:0] x_q  [ORDER];
   logic signed [STATE_W-1:0] x_nx [ORDER];
   logic [ORDER-1:0]          sat_v;
   logic signed [CODE_W-1:0]  code_q;
   logic signed [CODE_W-1:0]  q_code;
   logic                      q_clip;
   logic signed [ACC_W-1:0]   code_fb;

   assign code_fb = ACC_W'(code_q) <<< QSHIFT;

   for (genvar i = 0; i < ORDER; i++) begin : g_stage
      logic signed [ACC_W-1:0] fwd;
      logic signed [ACC_W-1:0] res;
      logic signed [ACC_W-1:0] drive;

      if (i == 0) begin : g_head
         assign fwd = ACC_W'(B_COEF) * ACC_W'(in_sample);
      end else begin : g_chain
         assign fwd = ACC_W'(C_COEF[i-1]) * ACC_W'(x_q[i-1]);
      end

      if (takes_resonator(i)) begin : g_res
         assign res = ACC_W'(G_COEF[res_slot(i)]) * ACC_W'(x_q[i+1]);
      end else begin : g_nores
         assign res = '0;
      end

      assign drive = fwd - res - ACC_W'(A_COEF[i]) * code_fb;

      nsh_integrator #(
         .STATE_W (STATE_W),
         .ACC_W   (ACC_W),
         .FRAC    (FRAC)
      ) u_int (
         .clk       (clk),
         .rst       (rst),
         .step      (in_valid),
         .drive     (drive),
         .state     (x_q[i]),
         .state_nxt (x_nx[i]),
         .sat       (sat_v[i])
      );
   end

   nsh_quantizer #(
      .STATE_W  (STATE_W),
      .QSHIFT   (QSHIFT),
      .MAX_CODE (MAX_CODE),
      .CODE_W   (CODE_W)
   ) u_quant (
      .level (x_nx[ORDER-1]),
      .code  (q_code),
      .clip  (q_clip)
   );

   // Single feedback register: the code of this step drives the next one.
   always_ff @(posedge clk) begin
      if (rst) begin
         code_q    <= '0;
         out_valid <= 1'b0;
         overload  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            code_q   <= q_code;
            overload <= overload | (|sat_v) | q_clip;
         end
      end
   end

   assign out_code = code_q;
endmodule

// File: rtl/nsh5_checker.sv
module nsh5_checker #(
   parameter int CODE_W   = 7,
   parameter int MAX_CODE = 32
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic                     out_valid,
   input logic signed [CODE_W-1:0] out_code,
   input logic                     overload
);
   localparam logic signed [CODE_W-1:0] CMAX = CODE_W'(MAX_CODE);
   localparam logic signed [CODE_W-1:0] CMIN = -CMAX;

   // R2: one code per accepted sample, one cycle later
   p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R3: idle cycles keep the outputs
   p_hold_code_r3: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_code));

   // R5: code stays within the level range
   p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
      (out_code <= CMAX) && (out_code >= CMIN));

   // R7: overload is sticky
   p_sticky_ovl_r7: assert property (@(posedge clk) disable iff (rst)
      overload |=> overload);
endmodule

bind nsh5_modulator nsh5_checker #(
   .CODE_W   (CODE_W),
   .MAX_CODE (MAX_CODE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_code  (out_code),
   .overload  (overload)
);

// File: tb/tb_nsh5_modulator.sv
module tb_nsh5_modulator;
   localparam int IN_W = 24, STATE_W = 24, COEF_W = 18, FRAC = 12, QSHIFT = 16;
   localparam int LEVELS = 65;
   localparam int B_C = 205;
   localparam int A_C [5] = '{205, 819, 1638, 2458, 3277};
   localparam int C_C [4] = '{4096, 4096, 4096, 4096};
   localparam int G_C [2] = '{8, 8};
   localparam longint SMAX = (longint'(1) <<< (STATE_W - 1)) - 1;
   localparam longint SMIN = -(longint'(1) <<< (STATE_W - 1));

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic signed [IN_W-1:0] in_sample = '0;
   logic out_valid;
   logic signed [6:0] out_code;
   logic overload;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   nsh5_modulator #(
      .IN_W(IN_W), .STATE_W(STATE_W), .COEF_W(COEF_W), .FRAC(FRAC),
      .QSHIFT(QSHIFT), .LEVELS(LEVELS), .B_COEF(B_C),
      .A_COEF(A_C), .C_COEF(C_C), .G_COEF(G_C)
   ) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(out_valid), .out_code(out_code), .overload(overload)
   );

   // Reference model state
   longint mx [5];
   longint mv;
   bit     movl;
   int     exp_code_q [$];
   bit     exp_ovl_q  [$];

   function automatic void model_reset();
      for (int i = 0; i < 5; i++) mx[i] = 0;
      mv   = 0;
      movl = 1'b0;
   endfunction

   // R4 R5 R6 R7: one loop step from the old state
   function automatic void model_step(longint u);
      longint nx [5];
      longint d, s, q;
      bit any = 1'b0;
      for (int i = 0; i < 5; i++) begin
         if (i == 0) d = longint'(B_C) * u;
         else        d = longint'(C_C[i-1]) * mx[i-1];
         d = d - longint'(A_C[i]) * (mv <<< QSHIFT);
         if (i == 1 || i == 3) d = d - longint'(G_C[(i-1)/2]) * mx[i+1];
         s = mx[i] + (d >>> FRAC);
         if (s > SMAX) begin s = SMAX; any = 1'b1; end
         if (s < SMIN) begin s = SMIN; any = 1'b1; end
         nx[i] = s;
      end
      q = (nx[4] + (longint'(1) <<< (QSHIFT - 1))) >>> QSHIFT;
      if (q > 32)  begin q = 32;  any = 1'b1; end
      if (q < -32) begin q = -32; any = 1'b1; end
      for (int i = 0; i < 5; i++) mx[i] = nx[i];
      mv   = q;
      movl = movl | any;
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Driver: one accepted sample, expected result pushed to the scoreboard
   task automatic drive_sample(longint u);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = IN_W'(u);
      model_step(u);
      exp_code_q.push_back(int'(mv));
      exp_ovl_q.push_back(movl);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor
   int  last_code = 0;
   bit  last_ovl  = 1'b0;
   always @(negedge clk) begin
      if (rst) begin
         last_code = 0;
         last_ovl  = 1'b0;
      end else if (out_valid) begin
         if (exp_code_q.size() == 0) begin
            check(1'b0, "R2", "code without accepted sample", 1, 0);
         end else begin
            int  ec;
            bit  eo;
            ec = exp_code_q.pop_front();
            eo = exp_ovl_q.pop_front();
            check(int'(out_code) == ec, "R4/R5", "code", int'(out_code), ec);
            check(overload == eo, "R6/R7", "overload", overload, eo);
         end
         last_code = int'(out_code);
         last_ovl  = overload;
      end else begin
         check(int'(out_code) == last_code, "R3", "code held in gap", int'(out_code), last_code);
         check(overload == last_ovl, "R3", "overload held in gap", overload, last_ovl);
      end
   end

   task automatic do_reset(int n);
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
      rst = 1'b0;
      model_reset();
      exp_code_q.delete();
      exp_ovl_q.delete();
      // R1: reset state visible at the ports
      check(out_code == 0, "R1", "code after reset", int'(out_code), 0);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(overload == 1'b0, "R1", "overload after reset", overload, 0);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      model_reset();
      do_reset(4);

      // R8: zero input from zero state
      for (int n = 0; n < 40; n++) drive_sample(0);
      idle(2);
      check(out_code == 0, "R8", "code after zero input", int'(out_code), 0);
      check(overload == 1'b0, "R8", "overload after zero input", overload, 0);

      // R4: small triangle tone, back to back
      for (int n = 0; n < 600; n++) begin
         int ph;
         ph = n % 64;
         drive_sample(longint'((ph < 32 ? ph : 64 - ph) - 16) * 16384);
      end
      idle(2);

      // R3: samples with random idle gaps
      for (int n = 0; n < 300; n++) begin
         drive_sample(longint'($urandom_range(0, 400000)) - 200000);
         idle(int'($urandom_range(0, 3)));
      end
      idle(2);
      check(exp_code_q.size() == 0, "R2", "pending codes after gaps", exp_code_q.size(), 0);

      // R6 R7: full-scale input forces saturation and clipping
      for (int n = 0; n < 200; n++)
         drive_sample(((n / 50) % 2 == 0) ? SMAX : SMIN);
      idle(2);
      check(overload == 1'b1, "R7", "overload after full scale", overload, 1);

      // R7: flag stays set under quiet input
      for (int n = 0; n < 50; n++) drive_sample(0);
      idle(3);
      check(overload == 1'b1, "R7", "overload sticky", overload, 1);

      // R1: reset mid-run clears state; zero input then stays zero (R8)
      do_reset(2);
      for (int n = 0; n < 30; n++) drive_sample(0);
      idle(2);
      check(out_code == 0, "R1", "code after state clear", int'(out_code), 0);
      check(overload == 1'b0, "R1", "overload after state clear", overload, 0);
      check(exp_code_q.size() == 0, "R2", "pending codes at end", exp_code_q.size(), 0);

      finish_run();
   end
endmodule